// File: doc/BRIEF.md
# ISA I/O Cycle Recovery Timer

This block sits in a PCI-to-ISA bridge and keeps a minimum idle gap between back-to-back ISA I/O cycles. It runs on the PCI clock. A programmable divider turns that clock into an ISA clock-enable pulse, and all recovery time is counted in those pulses. When the ISA cycle engine finishes an I/O cycle, it strobes `done_i` and tags the strobe with the cycle's width and direction. The block then counts ISA clocks. A pending request, tagged in the same way, is granted once enough ISA clocks have passed for that pair of cycle types.

There are two recovery fields, each 4 bits wide. One applies between back-to-back 16-bit I/O cycles of either direction. The other applies only between back-to-back 8-bit reads. Each field value v gives v+1 ISA clocks, and the block always adds one more built-in clock. Any other pairing is granted on the next ISA clock. The block latches the divisor and recovery settings when a cycle completes, so a write made while a window is running changes only later windows.

Top module: `isa_io_recovery`

## Requirements
- R1: Writing `cfg_wdata_i[2:0]` with `cfg_sel_i`=0 sets divisor field d. `isa_ce_o` then pulses once every d+1 clocks. The field resets to 000, which gives a pulse on every clock.
- R2: Writing `cfg_wdata_i` with `cfg_sel_i`=1 sets the recovery register. Bits 7:4 hold the 8-bit read field and bits 3:0 hold the 16-bit field. The register resets to 40h.
- R3: A 16-bit request (`req_wide_i`=1) that follows a completed 16-bit cycle, of either direction, is granted on the (f16+2)-th `isa_ce_o` pulse after `done_i`.
- R4: An 8-bit read request (`req_wide_i`=0, `req_rd_i`=1) that follows a completed 8-bit read is granted on the (f8+2)-th `isa_ce_o` pulse after `done_i`.
- R5: Any other pairing is granted on the first `isa_ce_o` pulse after `done_i`. This covers a width mismatch and an 8-bit pairing that involves a write.
- R6: A request made before any cycle has completed since reset is granted on the next `isa_ce_o` pulse.
- R7: `grant_o` is registered. It rises in the clock after the enabling `isa_ce_o` pulse and stays high while `req_i` is held. It falls in the clock after `req_i` drops or after `done_i` is strobed.
- R8: A configuration write made while a recovery window is running does not change that window or the current ISA clock period. The new values apply from the next `done_i`.
- R9: After reset, `grant_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PCI clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0: divisor field, 1: recovery register |
| cfg_wdata_i | input | 8 | Configuration write data |
| done_i | input | 1 | I/O cycle completed (one-clock strobe) |
| done_wide_i | input | 1 | Completed cycle was 16-bit |
| done_rd_i | input | 1 | Completed cycle was a read |
| req_i | input | 1 | New I/O cycle requested (level) |
| req_wide_i | input | 1 | Requested cycle is 16-bit |
| req_rd_i | input | 1 | Requested cycle is a read |
| grant_o | output | 1 | Recovery satisfied, cycle may start |
| isa_ce_o | output | 1 | ISA clock enable from the divider |

## Verification
The main timing is tried with every pairing of previous and next cycle kind. The 16-bit read and write pairings show that direction is ignored at 16 bits. An 8-bit read after an 8-bit read is set against 8-bit pairings that include a write, which shows where the 8-bit field applies. Width mismatches show that no recovery is added. The bench counts ISA enable pulses at the port rather than PCI clocks. This separates the programmed-plus-one count from off-by-one errors and from divider phase. A configuration write in the middle of a window, with a different divisor, shows whether the block latches the settings per window.

// File: rtl/isa_rec_pkg.sv
package isa_rec_pkg;
  localparam int unsigned DIV_W  = 3;
  localparam int unsigned REC_W  = 4;
  localparam int unsigned ELAP_W = 5;

  typedef struct packed {
    logic wide;
    logic rd;
  } io_kind_t;

  // recovery ticks needed before a request of kind nxt after a cycle of kind prv
  function automatic logic [ELAP_W-1:0] need_ticks(
    input logic             prv_valid,
    input io_kind_t         prv,
    input io_kind_t         nxt,
    input logic [REC_W-1:0] f8,
    input logic [REC_W-1:0] f16
  );
    logic [ELAP_W-1:0] n;
    n = ELAP_W'(1);
    if (prv_valid && prv.wide && nxt.wide)
      n = ELAP_W'(f16) + ELAP_W'(2);
    else if (prv_valid && !prv.wide && !nxt.wide && prv.rd && nxt.rd)
      n = ELAP_W'(f8) + ELAP_W'(2);
    return n;
  endfunction
endpackage

// File: rtl/isa_clk_div.sv
module isa_clk_div #(
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             ce_o
);
  logic [DIV_W-1:0] cnt_q;

  assign ce_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (ce_o) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/isa_rec_cfg.sv
module isa_rec_cfg #(
  parameter int unsigned          DIV_W   = 3,
  parameter int unsigned          REC_W   = 4,
  parameter logic [DIV_W-1:0]     DIV_RST = '0,
  parameter logic [2*REC_W-1:0]   REC_RST = 8'h40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               sel_i,
  input  logic [7:0]         wdata_i,
  input  logic               load_i,
  output logic [DIV_W-1:0]   div_act_o,
  output logic [REC_W-1:0]   f8_act_o,
  output logic [REC_W-1:0]   f16_act_o
);
  logic [DIV_W-1:0]   div_q;
  logic [2*REC_W-1:0] rec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DIV_RST;
      rec_q <= REC_RST;
    end else if (we_i) begin
      if (sel_i) rec_q <= wdata_i[2*REC_W-1:0];
      else       div_q <= wdata_i[DIV_W-1:0];
    end
  end

  // active copies: frozen for the whole recovery window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_act_o <= DIV_RST;
      f8_act_o  <= REC_RST[2*REC_W-1:REC_W];
      f16_act_o <= REC_RST[REC_W-1:0];
    end else if (load_i) begin
      div_act_o <= div_q;
      f8_act_o  <= rec_q[2*REC_W-1:REC_W];
      f16_act_o <= rec_q[REC_W-1:0];
    end
  end
endmodule

// File: rtl/isa_rec_timer.sv
module isa_rec_timer
  import isa_rec_pkg::*;
#(
  parameter int unsigned RW = 4,
  parameter int unsigned EW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic          done_i,
  input  io_kind_t      done_kind_i,
  input  logic          req_i,
  input  io_kind_t      req_kind_i,
  input  logic [RW-1:0] f8_i,
  input  logic [RW-1:0] f16_i,
  output logic          prv_valid_o,
  output logic [EW-1:0] elapsed_o,
  output logic          grant_o
);
  localparam logic [EW-1:0] ELAP_MAX = '1;

  io_kind_t        prv_q;
  logic [EW-1:0]   need;
  logic [EW:0]     elap_inc;
  logic            ready;

  always_comb begin
    need     = need_ticks(prv_valid_o, prv_q, req_kind_i, f8_i, f16_i);
    elap_inc = {1'b0, elapsed_o} + 1'b1;
    ready    = ce_i && (elap_inc >= {1'b0, need});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prv_valid_o <= 1'b0;
      prv_q       <= '0;
      elapsed_o   <= '0;
      grant_o     <= 1'b0;
    end else if (done_i) begin
      prv_valid_o <= 1'b1;
      prv_q       <= done_kind_i;
      elapsed_o   <= '0;
      grant_o     <= 1'b0;
    end else begin
      if (ce_i && elapsed_o != ELAP_MAX) elapsed_o <= elapsed_o + 1'b1;
      if (!req_i)     grant_o <= 1'b0;
      else if (ready) grant_o <= 1'b1;
    end
  end
endmodule

// File: rtl/isa_io_recovery.sv
module isa_io_recovery
  import isa_rec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic       cfg_sel_i,
  input  logic [7:0] cfg_wdata_i,
  input  logic       done_i,
  input  logic       done_wide_i,
  input  logic       done_rd_i,
  input  logic       req_i,
  input  logic       req_wide_i,
  input  logic       req_rd_i,
  output logic       grant_o,
  output logic       isa_ce_o
);
  logic [DIV_W-1:0]  div_act;
  logic [REC_W-1:0]  f8_act;
  logic [REC_W-1:0]  f16_act;
  logic              prv_valid;
  logic [ELAP_W-1:0] elapsed;
  io_kind_t          done_kind;
  io_kind_t          req_kind;

  assign done_kind = '{wide: done_wide_i, rd: done_rd_i};
  assign req_kind  = '{wide: req_wide_i,  rd: req_rd_i};

  isa_rec_cfg #(
    .DIV_W  (DIV_W),
    .REC_W  (REC_W),
    .DIV_RST(3'b000),
    .REC_RST(8'h40)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .sel_i    (cfg_sel_i),
    .wdata_i  (cfg_wdata_i),
    .load_i   (done_i || !prv_valid),
    .div_act_o(div_act),
    .f8_act_o (f8_act),
    .f16_act_o(f16_act)
  );

  isa_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_i (div_act),
    .ce_o  (isa_ce_o)
  );

  isa_rec_timer #(.RW(REC_W), .EW(ELAP_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_i       (isa_ce_o),
    .done_i     (done_i),
    .done_kind_i(done_kind),
    .req_i      (req_i),
    .req_kind_i (req_kind),
    .f8_i       (f8_act),
    .f16_i      (f16_act),
    .prv_valid_o(prv_valid),
    .elapsed_o  (elapsed),
    .grant_o    (grant_o)
  );
endmodule

// File: rtl/isa_rec_chk.sv
module isa_rec_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       done_i,
  input logic       req_i,
  input logic       grant_o,
  input logic       isa_ce_o,
  input logic [2:0] div_act
);
  AST_GRANT_AFTER_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> $past(isa_ce_o)); // R7
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> $past(req_i)); // R7
  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !grant_o); // R7
  AST_DIV1_EVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_act == 3'd0) |-> isa_ce_o); // R1
endmodule

bind isa_io_recovery isa_rec_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .done_i  (done_i),
  .req_i   (req_i),
  .grant_o (grant_o),
  .isa_ce_o(isa_ce_o),
  .div_act (div_act)
);

// File: tb/isa_io_recovery_bench.sv
module isa_io_recovery_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic       done_i = 1'b0, done_wide_i = 1'b0, done_rd_i = 1'b0;
  logic       req_i = 1'b0, req_wide_i = 1'b0, req_rd_i = 1'b0;
  logic       grant_o, isa_ce_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] f8_m = 4'h4, f16_m = 4'h0;

  always #2.5 clk_i = ~clk_i;

  isa_io_recovery u_isa_io_recovery (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // count ce pulses until grant is seen; called at a negedge
  task automatic wait_grant(output int n);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      if (grant_o) break;
      if (isa_ce_o) n++;
      @(negedge clk_i);
    end
    if (!grant_o) n = -1;
  endtask

  // clocks between two consecutive ce pulses
  task automatic ce_period(output int p);
    p = 0;
    for (int i = 0; i < 50 && !isa_ce_o; i++) @(negedge clk_i);
    @(negedge clk_i); p = 1;
    for (int i = 0; i < 50 && !isa_ce_o; i++) begin @(negedge clk_i); p++; end
  endtask

  function automatic int exp_need(input logic pw, input logic pr, input logic nw, input logic nr);
    if (pw && nw) return f16_m + 2;
    if (!pw && !nw && pr && nr) return f8_m + 2;
    return 1;
  endfunction

  task automatic release_req();
    @(negedge clk_i); req_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R9 grant low after reset", grant_o, 0);
    chk("R1 ce every clock at reset", isa_ce_o, 1);
  endtask

  task automatic t_first_req();
    int n;
    @(negedge clk_i);
    req_i = 1'b1; req_wide_i = 1'b0; req_rd_i = 1'b1;
    wait_grant(n);
    chk("R6 first request granted on next ce", n, 1);
    release_req();
  endtask

  task automatic t_divider(input logic [2:0] d);
    int p;
    cfg_write(1'b0, {5'b0, d});
    repeat (12) @(negedge clk_i);
    ce_period(p);
    chk($sformatf("R1 ce period div=%0d", d), p, d + 1);
  endtask

  task automatic t_pair(input string tag, input logic pw, input logic pr,
                        input logic nw, input logic nr);
    int n;
    @(negedge clk_i);
    done_i = 1'b1; done_wide_i = pw; done_rd_i = pr;
    req_i = 1'b1; req_wide_i = nw; req_rd_i = nr;
    @(negedge clk_i);
    done_i = 1'b0;
    wait_grant(n);
    chk(tag, n, exp_need(pw, pr, nw, nr));
    release_req();
  endtask

  task automatic t_hold_release();
    int n;
    @(negedge clk_i);
    done_i = 1'b1; done_wide_i = 1'b1; done_rd_i = 1'b0;
    req_i = 1'b1; req_wide_i = 1'b0; req_rd_i = 1'b0;
    @(negedge clk_i);
    done_i = 1'b0;
    wait_grant(n);
    repeat (9) @(negedge clk_i);
    chk("R7 grant held while req high", grant_o, 1);
    done_i = 1'b1; done_wide_i = 1'b0;
    @(negedge clk_i);
    done_i = 1'b0;
    chk("R7 done clears grant", grant_o, 0);
    wait_grant(n);
    chk("R7 regrant after done", grant_o, 1);
    @(negedge clk_i); req_i = 1'b0;
    @(negedge clk_i);
    chk("R7 grant drops after req falls", grant_o, 0);
  endtask

  task automatic t_cfg_during();
    int n, p;
    // window runs with f16=0, period 2
    cfg_write(1'b1, 8'h40); f8_m = 4'h4; f16_m = 4'h0;
    cfg_write(1'b0, 8'h01);
    @(negedge clk_i);
    done_i = 1'b1; done_wide_i = 1'b1; done_rd_i = 1'b1;
    @(negedge clk_i);
    done_i = 1'b0;
    cfg_we_i = 1'b1; cfg_sel_i = 1'b1; cfg_wdata_i = 8'h2F;
    @(negedge clk_i);
    cfg_sel_i = 1'b0; cfg_wdata_i = 8'h03;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    ce_period(p);
    chk("R8 period unchanged mid-window", p, 2);
    req_i = 1'b1; req_wide_i = 1'b1; req_rd_i = 1'b0;
    wait_grant(n);
    chk("R8 old window already met", grant_o, 1);
    release_req();
    f8_m = 4'h2; f16_m = 4'hF;
    t_pair("R8 new f16 applies next window", 1'b1, 1'b0, 1'b1, 1'b1);
    ce_period(p);
    chk("R8 new divisor applies next window", p, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_first_req();
    t_divider(3'd2);
    t_divider(3'd5);
    t_divider(3'd0);
    // reset-value recovery register (R2): f8=4, f16=0
    t_pair("R2 R4 8-bit rd after rd reset fields", 1'b0, 1'b1, 1'b0, 1'b1);
    t_pair("R2 R3 16-bit after 16-bit reset fields", 1'b1, 1'b1, 1'b1, 1'b1);
    cfg_write(1'b0, 8'h03);
    cfg_write(1'b1, 8'h73); f8_m = 4'h7; f16_m = 4'h3;
    t_pair("R3 16 wr after 16 rd", 1'b1, 1'b1, 1'b1, 1'b0);
    t_pair("R3 16 rd after 16 wr", 1'b1, 1'b0, 1'b1, 1'b1);
    t_pair("R3 16 wr after 16 wr", 1'b1, 1'b0, 1'b1, 1'b0);
    t_pair("R4 8 rd after 8 rd", 1'b0, 1'b1, 1'b0, 1'b1);
    t_pair("R5 8 wr after 8 rd", 1'b0, 1'b1, 1'b0, 1'b0);
    t_pair("R5 8 rd after 8 wr", 1'b0, 1'b0, 1'b0, 1'b1);
    t_pair("R5 16 after 8", 1'b0, 1'b1, 1'b1, 1'b1);
    t_pair("R5 8 after 16", 1'b1, 1'b1, 1'b0, 1'b1);
    cfg_write(1'b1, 8'hF0); f8_m = 4'hF; f16_m = 4'h0;
    t_pair("R4 max 8-bit field", 1'b0, 1'b1, 1'b0, 1'b1);
    t_hold_release();
    t_cfg_during();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule